// File: doc/BRIEF.md
# Two-Wire Bus Condition Monitor

This block sits beside a shared two-wire serial bus (one clock line, one data line) and only listens. It brings both line levels into the system clock domain, finds edges on them, and reports bus conditions as one-cycle pulses. A START opens a transaction and a STOP closes it. A START inside an open transaction is a repeated START. A data-line change while the clock line is high, in the middle of a byte, is reported as an abort.

While a transaction is open, the block counts clock-line rising edges so that it knows where it is inside a byte. A data-line change is accepted as START or STOP only in the first bit slot of a byte. The busy level rises with a START. After a STOP, busy stays high for a programmed number of system clock cycles. A fresh START during that tail keeps busy high without a gap. The block does not decode addresses or data.

Top module: `twowire_cond_mon`

## Requirements
- R1: Each reported condition is a one-cycle pulse, and at most one of the four pulses is high in any cycle. The pulse appears on the third rising system clock edge after the line change that causes it: two synchronizer flops, then the registered output.
- R2: With no transaction open, a high-to-low data change while the clock line is high gives `start_p`. `busy` is high in that same cycle.
- R3: With a transaction open and `bit_pos` = 0, a high-to-low data change while the clock line is high gives `rstart_p` instead of `start_p`. `busy` stays high.
- R4: With a transaction open and `bit_pos` = 0, a low-to-high data change while the clock line is high gives `stop_p` and closes the transaction.
- R5: After `stop_p`, `busy` stays high for exactly `hold_cycles` cycles, counting the `stop_p` cycle as the first, and is low after that. With `hold_cycles` = 0, `busy` is already low in the `stop_p` cycle.
- R6: A START during the post-STOP hold gives `start_p` (not `rstart_p`), cancels the countdown, and `busy` never drops.
- R7: `bit_pos` is 0 after any START. The first clock rising edge after a START leaves it at 0. Each later rising edge adds 1, wrapping from 8 (acknowledge slot) to 0.
- R8: With a transaction open and `bit_pos` not 0, any data change while the clock line is high gives `abort_p`. The transaction closes with no hold: `busy` and `bit_pos` are 0 in the `abort_p` cycle.
- R9: Data changes while the clock line is low produce no pulse and leave `bit_pos` unchanged. A low-to-high data change with the clock line high and no transaction open produces no pulse and leaves `busy` low.
- R10: During reset all pulses are low, `busy` is low and `bit_pos` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Raw bus clock line level |
| sda_in | input | 1 | Raw bus data line level |
| hold_cycles | input | HOLD_W | Post-STOP busy hold, in system clock cycles |
| start_p | output | 1 | START seen with no transaction open |
| rstart_p | output | 1 | Repeated START seen inside a transaction |
| stop_p | output | 1 | STOP seen |
| abort_p | output | 1 | Illegal mid-byte data change |
| busy | output | 1 | Bus busy level |
| bit_pos | output | 4 | Bit slot within the current byte, 0 to 8 |

## Verification
The bench aims at the byte boundary. A repeated START right after an acknowledge slot must be legal, and a data flip three bits into a byte must abort. A counter that miscounts the first rising edge after START would flag the legal case as an abort, or take the illegal one for a STOP. The hold window is traced cycle by cycle after STOP, for a nonzero and a zero setting, to catch off-by-one release of `busy`. A START landing inside a long hold must come out as a plain START with `busy` never dropping. Data toggles while the clock is low, and a stray rise while idle, must produce no pulse at all.

// File: rtl/twowire_cond_mon.sv
module twowire_cond_mon #(
  parameter int HOLD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_in,
  input  logic              sda_in,
  input  logic [HOLD_W-1:0] hold_cycles,
  output logic              start_p,
  output logic              rstart_p,
  output logic              stop_p,
  output logic              abort_p,
  output logic              busy,
  output logic [3:0]        bit_pos
);

  localparam logic [3:0] LAST_SLOT = 4'd8;

  logic [1:0]        scl_sy, sda_sy;
  logic              scl_d, sda_d;
  logic              in_txn, fresh;
  logic [HOLD_W-1:0] hold_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sy <= 2'b11;
      sda_sy <= 2'b11;
      scl_d  <= 1'b1;
      sda_d  <= 1'b1;
    end else begin
      scl_sy <= {scl_sy[0], scl_in};
      sda_sy <= {sda_sy[0], sda_in};
      scl_d  <= scl_sy[1];
      sda_d  <= sda_sy[1];
    end
  end

  wire scl_hi   = scl_sy[1] & scl_d;
  wire scl_rise = scl_sy[1] & ~scl_d;
  wire sda_fall = scl_hi & sda_d & ~sda_sy[1];
  wire sda_rise = scl_hi & ~sda_d & sda_sy[1];
  wire at_edge  = (bit_pos == 4'd0);

  wire ev_start  = sda_fall & ~in_txn;
  wire ev_rstart = sda_fall & in_txn & at_edge;
  wire ev_stop   = sda_rise & in_txn & at_edge;
  wire ev_abort  = (sda_fall | sda_rise) & in_txn & ~at_edge;

  assign busy = in_txn | (hold_cnt != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_p  <= 1'b0;
      rstart_p <= 1'b0;
      stop_p   <= 1'b0;
      abort_p  <= 1'b0;
      in_txn   <= 1'b0;
      fresh    <= 1'b1;
      bit_pos  <= 4'd0;
      hold_cnt <= '0;
    end else begin
      start_p  <= ev_start;
      rstart_p <= ev_rstart;
      stop_p   <= ev_stop;
      abort_p  <= ev_abort;
      if (ev_start || ev_rstart) begin
        in_txn   <= 1'b1;
        hold_cnt <= '0;
        bit_pos  <= 4'd0;
        fresh    <= 1'b1;
      end else if (ev_stop || ev_abort) begin
        in_txn   <= 1'b0;
        hold_cnt <= ev_stop ? hold_cycles : '0;
        bit_pos  <= 4'd0;
        fresh    <= 1'b1;
      end else begin
        if (hold_cnt != '0)
          hold_cnt <= hold_cnt - 1'b1;
        if (in_txn && scl_rise) begin
          if (fresh)
            fresh <= 1'b0;
          else
            bit_pos <= (bit_pos == LAST_SLOT) ? 4'd0 : bit_pos + 4'd1;
        end
      end
    end
  end

  AST_ONE_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({start_p, rstart_p, stop_p, abort_p})); // R1
  AST_START_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
    (start_p || rstart_p) |-> (busy && bit_pos == 4'd0)); // R2
  AST_RSTART_NEEDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    rstart_p |-> $past(busy)); // R3
  AST_STOP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_p && $past(hold_cycles) != '0) |-> busy); // R5
  AST_BITPOS_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    bit_pos <= LAST_SLOT); // R7
  AST_ABORT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    abort_p |-> (!busy && bit_pos == 4'd0)); // R8

endmodule

// File: tb/tb_twowire_cond_mon.sv
module tb_twowire_cond_mon;
  localparam int HW = 16;
  logic clk = 1'b0, rst_n = 1'b0, scl = 1'b1, sda = 1'b1;
  logic [HW-1:0] hold = 16'd3;
  logic start_p, rstart_p, stop_p, abort_p, busy;
  logic [3:0] bit_pos;
  int checks = 0, errors = 0;
  int exp_q[$];
  string req_q[$];

  twowire_cond_mon #(.HOLD_W(HW)) dut (
    .clk(clk), .rst_n(rst_n), .scl_in(scl), .sda_in(sda), .hold_cycles(hold),
    .start_p(start_p), .rstart_p(rstart_p), .stop_p(stop_p), .abort_p(abort_p),
    .busy(busy), .bit_pos(bit_pos));

  always #10 clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic w(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_ev(input int code, input string req);
    exp_q.push_back(code);
    req_q.push_back(req);
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      int code;
      code = start_p ? 1 : rstart_p ? 2 : stop_p ? 3 : abort_p ? 4 : 0;
      if (code != 0) begin
        if (exp_q.size() == 0) check(1'b0, "R9 unexpected event", code, 0);
        else begin
          int e;
          string r;
          e = exp_q.pop_front();
          r = req_q.pop_front();
          check(code == e, r, code, e);
        end
      end
    end
  end

  task automatic send_bit(input bit b);
    sda = b; w(4);
    scl = 1'b1; w(4);
    scl = 1'b0; w(4);
  endtask

  task automatic send_bits(input int n);
    for (int i = 0; i < n; i++) send_bit(i[0]);
  endtask

  task automatic do_start(input string req);
    expect_ev(1, req);
    sda = 1'b0; w(4);
    scl = 1'b0; w(4);
  endtask

  task automatic do_stop(input bit trace);
    sda = 1'b0; w(4);
    scl = 1'b1; w(4);
    expect_ev(3, "R4 stop");
    sda = 1'b1;
    w(3);
    if (trace) begin
      for (int k = 0; k <= int'(hold); k++) begin
        check(busy == (k < int'(hold)), "R5 busy hold trace", busy, k < int'(hold));
        w(1);
      end
    end
  endtask

  initial begin
    w(4);
    check(!start_p && !rstart_p && !stop_p && !abort_p, "R10 pulses in reset", 0, 0);
    check(!busy && bit_pos == 0, "R10 busy/bit_pos in reset", {busy, bit_pos}, 0);
    rst_n = 1'b1; w(5);

    expect_ev(1, "R2 start");
    sda = 1'b0;
    w(2);
    check(start_p == 1'b0, "R1 no pulse before third edge", start_p, 0);
    w(1);
    check(start_p == 1'b1, "R1 pulse on third edge", start_p, 1);
    check(busy == 1'b1, "R2 busy with start", busy, 1);
    w(1);
    check(start_p == 1'b0, "R1 single-cycle pulse", start_p, 0);
    w(2);
    scl = 1'b0; w(4);

    send_bits(3);
    check(bit_pos == 4'd2, "R7 bit_pos after three bits", bit_pos, 2);
    send_bits(6);
    check(bit_pos == 4'd8, "R7 bit_pos at ack slot", bit_pos, 8);

    sda = 1'b1; w(4);
    scl = 1'b1; w(4);
    check(bit_pos == 4'd0, "R7 wrap to 0", bit_pos, 0);
    expect_ev(2, "R3 repeated start");
    sda = 1'b0; w(4);
    check(busy == 1'b1 && bit_pos == 0, "R3 busy kept after rstart", busy, 1);
    scl = 1'b0; w(4);

    sda = 1'b1; w(4);
    sda = 1'b0; w(4);
    sda = 1'b1; w(4);
    check(bit_pos == 4'd0, "R9 low-phase toggles keep bit_pos", bit_pos, 0);
    send_bits(9);
    hold = 16'd3;
    do_stop(1'b1);

    hold = 16'd0;
    do_start("R2 start hold0");
    send_bits(9);
    do_stop(1'b1);

    hold = 16'd30;
    do_start("R2 start hold30");
    send_bits(9);
    do_stop(1'b0);
    w(3);
    check(busy == 1'b1, "R5 busy inside hold", busy, 1);
    expect_ev(1, "R6 start during hold");
    sda = 1'b0;
    for (int k = 0; k < 8; k++) begin
      check(busy == 1'b1, "R6 busy never drops", busy, 1);
      w(1);
    end
    scl = 1'b0; w(4);
    hold = 16'd0;
    send_bits(9);
    do_stop(1'b1);

    do_start("R2 start abort case");
    send_bits(3);
    sda = 1'b1; w(4);
    scl = 1'b1; w(4);
    check(bit_pos == 4'd3, "R7 bit_pos fourth slot", bit_pos, 3);
    expect_ev(4, "R8 abort");
    sda = 1'b0;
    w(3);
    check(!busy && bit_pos == 0, "R8 abort clears busy/bit_pos", {busy, bit_pos}, 0);
    w(2);
    scl = 1'b0; w(4);

    sda = 1'b1; w(4);
    sda = 1'b0; w(4);
    scl = 1'b1; w(4);
    sda = 1'b1; w(6);
    check(busy == 1'b0, "R9 idle rise leaves busy low", busy, 0);

    w(10);
    check(exp_q.size() == 0, "R1 all expected events seen", exp_q.size(), 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule